// File: doc/BRIEF.md
# Parallel Port Extended-Mode Peripheral Link

This block is the device end of a host parallel port working in the extended-capability transfer mode. One 8-bit data path from the host carries two kinds of forward byte. The level of the host's acknowledge/mode line when its strobe falls sets the kind: a command byte or a data byte. A command byte with its top bit set loads a 7-bit channel number. That number then steers every data byte that follows onto an internal function bus. A command byte with its top bit clear is a run-length count. The link does not support run-length counts: it flags them and discards them.

When the host requests a reverse transfer, the link reads one byte from the function bus at the current channel. It drives that byte onto the data pins from a register and strobes it back to the host with a two-phase handshake. It then releases the pins. All host control lines pass through two flip-flops into the local clock domain before the link uses them.

Top module: `ecp_periph_link`

## Requirements
- R1: While reset is applied and just after it, the channel is 0, `pad_oe` is 0, `periph_ack` is 0, `periph_strobe_n` is 1, and `fn_wr`, `fn_rd` and `rle_seen` are 0.
- R2: A forward byte latched on a falling `host_strobe_n` while `host_mode` is 1 is a data byte. It gives exactly one single-cycle `fn_wr` pulse, with `fn_wdata` equal to the byte and `fn_addr` equal to the current channel.
- R3: A forward byte latched while `host_mode` is 0 with bit 7 = 1 is a channel command. It sets the channel to bits 6:0 and gives no `fn_wr`.
- R4: A forward byte latched while `host_mode` is 0 with bit 7 = 0 is a run-length command. It leaves the channel unchanged, gives no `fn_wr`, and gives a single-cycle `rle_seen` pulse.
- R5: After the link latches a forward byte, `periph_ack` goes high. It stays high as long as `host_strobe_n` is low, and no further byte is accepted in that time. It returns low once `host_strobe_n` is high again.
- R6: `pad_oe` is 0 throughout every forward transfer. The data pins are driven only inside a reverse transfer.
- R7: A reverse request gives one single-cycle `fn_rd` pulse at the current channel. `pad_data_out` then shows the `fn_rdata` value from that cycle and stays stable for as long as `pad_oe` is 1.
- R8: The reverse handshake runs in this order. `pad_oe` rises before `periph_strobe_n` falls. `periph_strobe_n` stays low until `host_mode` goes high, then returns high. `pad_oe` falls only after `host_mode` is low again.
- R9: If a strobe fall and a reverse request reach the link in the same cycle, the forward byte is accepted and written first. The reverse read follows after the forward handshake ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe_n | input | 1 | Host forward strobe; a falling edge latches the byte |
| host_mode | input | 1 | Forward: 1 = data, 0 = command; reverse: host acknowledge |
| rev_req | input | 1 | Host request for a reverse transfer |
| pad_data_in | input | 8 | Byte on the data pins from the host |
| pad_data_out | output | 8 | Registered byte driven to the host in reverse |
| pad_oe | output | 1 | Output enable of the data pins (0 = tristated) |
| periph_ack | output | 1 | Forward acknowledge to the host |
| periph_strobe_n | output | 1 | Reverse strobe to the host, active low |
| fn_addr | output | 7 | Current channel number |
| fn_wdata | output | 8 | Write data to the function bus |
| fn_wr | output | 1 | Single-cycle write strobe |
| fn_rd | output | 1 | Single-cycle read strobe |
| fn_rdata | input | 8 | Read data returned by the function bus in the `fn_rd` cycle |
| rle_seen | output | 1 | Single-cycle flag for a discarded run-length command |

## Verification
A forward strobe edge and a reverse request can reach the idle controller in the same clock. To provoke this, the bench lowers `host_strobe_n` and raises `rev_req` in the same instant, so both pass through the synchronisers together. The scoreboard monitor records the cycle of each `fn_wr` and `fn_rd` pulse. The bench judges the case correct if the data write lands at the expected channel strictly before the read, and if the reverse byte then returns the function-bus value for that channel.

// File: rtl/ecp_link_pkg.sv
`timescale 1ns/1ps
package ecp_link_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD_ACK,
    ST_REV_RD,
    ST_REV_SETUP,
    ST_REV_WAIT_HI,
    ST_REV_WAIT_LO
  } link_st_e;

  // top bit of a command byte: 1 = channel number, 0 = run-length count
  function automatic logic is_chan_cmd(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [CHAN_W-1:0] chan_of(input logic [BYTE_W-1:0] b);
    return b[CHAN_W-1:0];
  endfunction
endpackage

// File: rtl/ecp_sync.sv
`timescale 1ns/1ps
module ecp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ecp_cmd_decode.sv
`timescale 1ns/1ps
module ecp_cmd_decode
  import ecp_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ev,
  input  logic              cap_mode,
  input  logic [BYTE_W-1:0] cap_byte,
  output logic [CHAN_W-1:0] chan,
  output logic [BYTE_W-1:0] fn_wdata,
  output logic              fn_wr,
  output logic              rle_seen
);
  // named events, visible to assertions
  logic data_ev, chan_ev, rle_ev;
  assign data_ev = cap_ev & cap_mode;
  assign chan_ev = cap_ev & ~cap_mode & is_chan_cmd(cap_byte);
  assign rle_ev  = cap_ev & ~cap_mode & ~is_chan_cmd(cap_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan     <= '0;
      fn_wdata <= '0;
      fn_wr    <= 1'b0;
      rle_seen <= 1'b0;
    end else begin
      fn_wr    <= data_ev;
      rle_seen <= rle_ev;
      if (data_ev) fn_wdata <= cap_byte;
      if (chan_ev) chan <= chan_of(cap_byte);
    end
  end

  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_wr |=> !fn_wr);
  p_rle_keeps_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rle_seen |-> chan == $past(chan));
  p_rle_no_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rle_seen |-> !fn_wr);
endmodule

// File: rtl/ecp_link_ctrl.sv
`timescale 1ns/1ps
module ecp_link_ctrl
  import ecp_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_strobe_n,
  input  logic              s_ack,
  input  logic              s_rev,
  input  logic [BYTE_W-1:0] pad_in,
  input  logic [BYTE_W-1:0] fn_rdata,
  output logic              cap_ev,
  output logic              cap_mode,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              periph_ack,
  output logic              periph_strobe_n,
  output logic [BYTE_W-1:0] pad_out,
  output logic              pad_oe,
  output logic              fn_rd
);
  link_st_e st;
  logic prev_strobe_n;
  logic fall_ev;

  assign fall_ev  = prev_strobe_n & ~s_strobe_n;
  assign cap_ev   = (st == ST_IDLE) & fall_ev;
  assign cap_mode = s_ack;
  assign cap_byte = pad_in;
  assign fn_rd    = (st == ST_REV_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      prev_strobe_n   <= 1'b1;
      periph_ack      <= 1'b0;
      periph_strobe_n <= 1'b1;
      pad_out         <= '0;
      pad_oe          <= 1'b0;
    end else begin
      prev_strobe_n <= s_strobe_n;
      unique case (st)
        ST_IDLE: begin
          if (fall_ev) begin          // forward wins a tie
            periph_ack <= 1'b1;
            st         <= ST_FWD_ACK;
          end else if (s_rev) begin
            st <= ST_REV_RD;
          end
        end
        ST_FWD_ACK: begin
          if (s_strobe_n) begin
            periph_ack <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        ST_REV_RD: begin
          pad_out <= fn_rdata;
          pad_oe  <= 1'b1;
          st      <= ST_REV_SETUP;
        end
        ST_REV_SETUP: begin
          periph_strobe_n <= 1'b0;
          st              <= ST_REV_WAIT_HI;
        end
        ST_REV_WAIT_HI: begin
          if (s_ack) begin
            periph_strobe_n <= 1'b1;
            st              <= ST_REV_WAIT_LO;
          end
        end
        ST_REV_WAIT_LO: begin
          if (!s_ack) begin
            pad_oe <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack && !s_strobe_n |=> periph_ack);
  p_ack_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> !pad_oe);
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rd |=> !fn_rd);
  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe && $past(pad_oe) |-> pad_out == $past(pad_out));
  p_strobe_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_strobe_n |-> pad_oe);
  p_no_cap_in_rev_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |-> !pad_oe);
endmodule

// File: rtl/ecp_periph_link.sv
`timescale 1ns/1ps
module ecp_periph_link
  import ecp_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_n,
  input  logic              host_mode,
  input  logic              rev_req,
  input  logic [BYTE_W-1:0] pad_data_in,
  output logic [BYTE_W-1:0] pad_data_out,
  output logic              pad_oe,
  output logic              periph_ack,
  output logic              periph_strobe_n,
  output logic [CHAN_W-1:0] fn_addr,
  output logic [BYTE_W-1:0] fn_wdata,
  output logic              fn_wr,
  output logic              fn_rd,
  input  logic [BYTE_W-1:0] fn_rdata,
  output logic              rle_seen
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] s_ctrl;
  logic              cap_ev, cap_mode;
  logic [BYTE_W-1:0] cap_byte;

  ecp_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_strobe_n, host_mode, rev_req}),
    .q(s_ctrl)
  );

  ecp_link_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_strobe_n(s_ctrl[2]), .s_ack(s_ctrl[1]), .s_rev(s_ctrl[0]),
    .pad_in(pad_data_in), .fn_rdata(fn_rdata),
    .cap_ev(cap_ev), .cap_mode(cap_mode), .cap_byte(cap_byte),
    .periph_ack(periph_ack), .periph_strobe_n(periph_strobe_n),
    .pad_out(pad_data_out), .pad_oe(pad_oe), .fn_rd(fn_rd)
  );

  ecp_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .cap_ev(cap_ev), .cap_mode(cap_mode), .cap_byte(cap_byte),
    .chan(fn_addr), .fn_wdata(fn_wdata), .fn_wr(fn_wr), .rle_seen(rle_seen)
  );

  p_wr_rd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn_wr && fn_rd));
endmodule

// File: tb/sim_ecp_periph_link.sv
`timescale 1ns/1ps
module sim_ecp_periph_link;
  logic clk = 0, rst_n = 0;
  logic host_strobe_n = 1, host_mode = 0, rev_req = 0;
  logic [7:0] pad_data_in = 0;
  logic [7:0] pad_data_out, fn_wdata, fn_rdata;
  logic [6:0] fn_addr;
  logic pad_oe, periph_ack, periph_strobe_n, fn_wr, fn_rd, rle_seen;

  always #2 clk = ~clk;   // 250 MHz

  ecp_periph_link u0 (.*);

  function automatic logic [7:0] rd_model(input logic [6:0] a);
    return {a, 1'b1} ^ 8'hC3;
  endfunction
  assign fn_rdata = rd_model(fn_addr);

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, rle_cnt = 0, cyc = 0, last_wr_cyc = 0, last_rd_cyc = 0;
  logic [6:0] rd_addr_seen;
  logic [6:0] model_chan = 0;
  logic [14:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (fn_wr) begin
      wr_cnt++; last_wr_cyc = cyc;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected write actual=%0h expected=none", {fn_addr, fn_wdata});
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        if ({fn_addr, fn_wdata} !== e) begin
          errors++;
          $display("FAIL R2 write addr/data actual=%0h expected=%0h", {fn_addr, fn_wdata}, e);
        end
      end
    end
    if (fn_rd) begin rd_cnt++; last_rd_cyc = cyc; rd_addr_seen = fn_addr; end
    if (rle_seen) rle_cnt++;
  end

  task automatic wait_ack(input logic v);
    for (int i = 0; i < 200 && periph_ack !== v; i++) @(negedge clk);
    chk(periph_ack === v, "R5", "ack wait", periph_ack, v);
  endtask
  task automatic wait_pstb(input logic v);
    for (int i = 0; i < 200 && periph_strobe_n !== v; i++) @(negedge clk);
    chk(periph_strobe_n === v, "R8", "strobe wait", periph_strobe_n, v);
  endtask

  task automatic host_fwd(input logic mode, input logic [7:0] b);
    pad_data_in = b; host_mode = mode;
    if (mode) exp_q.push_back({model_chan, b});
    else if (b[7]) model_chan = b[6:0];
    @(negedge clk);
    host_strobe_n = 0;
    wait_ack(1);
    chk(pad_oe === 0, "R6", "oe during forward", pad_oe, 0);
    host_strobe_n = 1;
    wait_ack(0);
    repeat (2) @(negedge clk);
  endtask

  task automatic host_rev();
    int rd0;
    rd0 = rd_cnt;
    rev_req = 1;
    wait_pstb(0);
    rev_req = 0;
    chk(pad_oe === 1, "R8", "oe before strobe", pad_oe, 1);
    chk(pad_data_out === rd_model(model_chan), "R7", "reverse byte", pad_data_out, rd_model(model_chan));
    chk(rd_cnt == rd0 + 1 && rd_addr_seen == model_chan, "R7", "one read at channel",
        rd_cnt - rd0, 1);
    repeat (6) @(negedge clk);
    chk(periph_strobe_n === 0, "R8", "strobe held until ack", periph_strobe_n, 0);
    host_mode = 1;
    wait_pstb(1);
    chk(pad_oe === 1 && pad_data_out === rd_model(model_chan), "R8", "bus held after strobe",
        pad_oe, 1);
    repeat (4) @(negedge clk);
    chk(pad_oe === 1, "R8", "oe held while ack high", pad_oe, 1);
    host_mode = 0;
    repeat (6) @(negedge clk);
    chk(pad_oe === 0, "R8", "bus released", pad_oe, 0);
    chk(rd_cnt == rd0 + 1, "R7", "no extra read", rd_cnt - rd0, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fn_addr == 0 && pad_oe === 0 && periph_ack === 0 && periph_strobe_n === 1 &&
        fn_wr === 0 && fn_rd === 0 && rle_seen === 0, "R1", "reset outputs",
        {fn_addr, pad_oe, periph_ack, periph_strobe_n}, 7'h0 << 3 | 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(fn_addr == 0 && pad_oe === 0 && periph_ack === 0, "R1", "after release", fn_addr, 0);

    // R2 data at channel 0
    host_fwd(1, 8'hA5);
    host_fwd(1, 8'h3C);
    // R3 channel commands
    w0 = wr_cnt;
    host_fwd(0, 8'h80 | 8'h2B);
    chk(fn_addr == 7'h2B, "R3", "channel set", fn_addr, 7'h2B);
    chk(wr_cnt == w0, "R3", "no write on command", wr_cnt - w0, 0);
    host_fwd(1, 8'h01);
    host_fwd(1, 8'hFF);
    // R4 run-length ignored
    r0 = rle_cnt; w0 = wr_cnt;
    host_fwd(0, 8'h05);
    chk(fn_addr == 7'h2B, "R4", "channel kept", fn_addr, 7'h2B);
    chk(rle_cnt == r0 + 1, "R4", "rle flag", rle_cnt - r0, 1);
    chk(wr_cnt == w0, "R4", "no write on rle", wr_cnt - w0, 0);
    host_fwd(1, 8'h77);
    host_fwd(0, 8'hFF);
    chk(fn_addr == 7'h7F, "R3", "top channel", fn_addr, 7'h7F);

    // R5 ack held while strobe low, single accept
    w0 = wr_cnt;
    pad_data_in = 8'h5A; host_mode = 1; exp_q.push_back({model_chan, 8'h5A});
    @(negedge clk); host_strobe_n = 0;
    wait_ack(1);
    repeat (10) @(negedge clk);
    pad_data_in = 8'h99;
    chk(periph_ack === 1, "R5", "ack held", periph_ack, 1);
    chk(wr_cnt == w0 + 1, "R5", "single accept", wr_cnt - w0, 1);
    host_strobe_n = 1;
    wait_ack(0);
    host_mode = 0;
    repeat (3) @(negedge clk);

    // R7/R8 reverse
    host_rev();
    host_fwd(0, 8'h80 | 8'h11);
    host_rev();

    // R9 collision: strobe fall and reverse request together
    host_mode = 1; pad_data_in = 8'hC7; exp_q.push_back({model_chan, 8'hC7});
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt;
    host_strobe_n = 0; rev_req = 1;
    wait_ack(1);
    host_mode = 0;
    host_strobe_n = 1;
    wait_pstb(0);
    rev_req = 0;
    chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R9", "both happened",
        (wr_cnt - w0) * 16 + rd_cnt - r0, 8'h11);
    chk(last_wr_cyc < last_rd_cyc, "R9", "write before read", last_wr_cyc, last_rd_cyc);
    chk(pad_data_out === rd_model(model_chan), "R9", "reverse byte after tie",
        pad_data_out, rd_model(model_chan));
    host_mode = 1;
    wait_pstb(1);
    host_mode = 0;
    repeat (6) @(negedge clk);
    chk(pad_oe === 0, "R9", "bus released", pad_oe, 0);

    chk(exp_q.size() == 0, "R2", "all writes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule